// File: doc/BRIEF.md
# Two-Channel Cycle-Steal DMA Controller

This block moves data between memory locations on behalf of a CPU, one unit at a time, by borrowing single bus cycles. Each of its two channels holds a source pointer, a destination pointer, a reload value and a control word. Every accepted request makes the controller read one 8-bit or 16-bit unit from the source and then write it to the destination over a 20-bit byte-addressed master port. At most one side of a channel may step forward after each unit. The other side stays at a fixed address, and both sides may be fixed.

Software programs the channels through a small register port. Requests come from three places: a write to a trigger register, an edge on a per-channel trigger pin, or a peripheral request line. The channel's control word selects which of the pin or peripheral sources is used. The transfer counter and the working forward pointer are loaded on the first transfer after the channel is enabled. When the counter underflows, the channel raises a one-cycle interrupt pulse. It then either switches itself off (single mode) or reloads the counter and keeps running (repeat mode).

The trigger pins and the peripheral request lines are taken to be synchronous to `clk`. Register reads return their data one cycle after the address is presented.

Top module: `dma2_cycle_steal`

## Requirements
- R1: When both channels hold a pending request while the sequencer is idle, channel 0 is served first. Channel 1 is served after channel 0's read-write pair completes.
- R2: A transfer raises `bus_req` with `bus_we`=0 at the source address and holds it until `bus_ready`. It then raises `bus_we` at the destination address until `bus_ready`, with `bus_wdata` equal to the read data. In 8-bit mode (control bit 2 = 0) only the low byte is kept and the upper byte is zero. `bus_size16` reflects control bit 2.
- R3: The first transfer after the enable bit (control bit 0) goes from 0 to 1 copies the forward register into the working pointer and the reload register into the counter. The forward register is the source if control bit 3 is set, or the destination if control bit 4 is set. After each unit the working pointer advances by 1 (8-bit) or 2 (16-bit).
- R4: A reload value N gives N+1 transfers until underflow. The counter (register index 4) decrements per unit. The unit completed with the counter at 0 is the underflow, and it produces a `dma_irq` pulse exactly one cycle wide for that channel.
- R5: In single mode (control bit 1 = 0), underflow clears the enable bit and further requests start no transfer.
- R6: In repeat mode (control bit 1 = 1), underflow reloads the counter from the reload register. The channel stays enabled and the working pointer continues from where it was.
- R7: A write to the source (index 1) or destination (index 2) register is ignored while the channel is enabled and that side is fixed. A write to a forward side is accepted at any time.
- R8: `reg_rdata` returns, one cycle after `reg_addr`, the register addressed by `reg_addr[3]` (channel) and `reg_addr[2:0]` (index). While the channel is enabled and has made its first transfer, reading the forward side returns the working pointer.
- R9: A control write with both bit 3 and bit 4 set keeps the source forward and stores the destination as fixed (bit 4 reads back 0).
- R10: A write to index 5 requests one transfer. Control bits 6:5 select the additional source: 1 = falling edge of the channel's trigger pin, 2 = either edge, 3 = high level on the peripheral request line. Requests are ignored while disabled. Several requests arriving before the channel is served yield a single transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Bit 3 channel, bits 2:0 register index |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Registered read data |
| trig_pin | input | 2 | Per-channel trigger pin |
| periph_req | input | 2 | Per-channel peripheral request level |
| bus_req | output | 1 | Bus cycle request (held during a transfer) |
| bus_we | output | 1 | 1 for the write access, 0 for the read access |
| bus_addr | output | 20 | Byte address |
| bus_wdata | output | 16 | Write data |
| bus_size16 | output | 1 | 1 for 16-bit units, 0 for 8-bit |
| bus_rdata | input | 16 | Read data from memory |
| bus_ready | input | 1 | Access completes on this cycle |
| dma_irq | output | 2 | Per-channel underflow pulse |

## Verification
A wrong internal value in this block shows up at the ports within a few cycles. A stale forward pointer or a missed lazy load appears on `bus_addr` in the read or write phase of the very next transfer. A wrong counter value moves the `dma_irq` pulse to the wrong unit, and a wrong enable value makes a later request start a transfer that should not happen, or suppresses one that should. Register protection and readback rules are visible on `reg_rdata` one cycle after the address is presented. A reference model that runs in step with the design therefore catches a divergence within one transfer of its cause.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_RD, SEQ_WR} seq_state_t;
  typedef enum logic [1:0] {TRG_SOFT = 2'd0, TRG_FALL = 2'd1, TRG_BOTH = 2'd2, TRG_PERIPH = 2'd3} trig_t;

  localparam int IDX_W = 3;
  localparam logic [IDX_W-1:0] IX_CTRL = 3'd0;
  localparam logic [IDX_W-1:0] IX_SRC  = 3'd1;
  localparam logic [IDX_W-1:0] IX_DST  = 3'd2;
  localparam logic [IDX_W-1:0] IX_RLD  = 3'd3;
  localparam logic [IDX_W-1:0] IX_CNT  = 3'd4;
  localparam logic [IDX_W-1:0] IX_KICK = 3'd5;

  localparam int CB_EN  = 0;
  localparam int CB_REP = 1;
  localparam int CB_SZ  = 2;
  localparam int CB_SF  = 3;
  localparam int CB_DF  = 4;
  localparam int CB_SEL = 5;
endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
  import dma2_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_val,
  input  logic              pin,
  input  logic              periph,
  input  logic              start,
  input  logic              done,
  output logic              pend_out,
  output logic              en_out,
  output logic              rep_out,
  output logic              sz_out,
  output logic [ADDR_W-1:0] src_eff,
  output logic [ADDR_W-1:0] dst_eff,
  output logic              irq
);
  logic              en, rep, sz, sf, df, fresh, pend, pin_q;
  trig_t             sel;
  logic [ADDR_W-1:0] src, dst, wp, step;
  logic [CNT_W-1:0]  rld, cnt;
  logic              kick, fall, rise, req_now;

  assign kick    = wr_en && (wr_idx == IX_KICK);
  assign fall    = pin_q && !pin;
  assign rise    = !pin_q && pin;
  assign req_now = en && (kick ||
                          (sel == TRG_FALL && fall) ||
                          (sel == TRG_BOTH && (fall || rise)) ||
                          (sel == TRG_PERIPH && periph));
  assign step    = sz ? ADDR_W'(2) : ADDR_W'(1);

  // Before the first transfer the stored register is the pointer itself.
  assign src_eff = (sf && !fresh) ? wp : src;
  assign dst_eff = (df && !fresh) ? wp : dst;

  always_comb begin
    rd_val = '0;
    case (rd_idx)
      IX_CTRL: rd_val = ADDR_W'({sel, df, sf, sz, rep, en});
      IX_SRC:  rd_val = (en && sf && !fresh) ? wp : src;
      IX_DST:  rd_val = (en && df && !fresh) ? wp : dst;
      IX_RLD:  rd_val = ADDR_W'(rld);
      IX_CNT:  rd_val = ADDR_W'(cnt);
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; rep <= 1'b0; sz <= 1'b0; sf <= 1'b0; df <= 1'b0;
      fresh <= 1'b0; pend <= 1'b0; pin_q <= 1'b0; irq <= 1'b0;
      sel <= TRG_SOFT; src <= '0; dst <= '0; wp <= '0; rld <= '0; cnt <= '0;
    end else begin
      irq   <= 1'b0;
      pin_q <= pin;
      if (!en)          pend <= 1'b0;
      else if (req_now) pend <= 1'b1;
      else if (done)    pend <= 1'b0;

      if (start && fresh) begin
        cnt   <= rld;
        wp    <= sf ? src : dst;
        fresh <= 1'b0;
      end

      if (done) begin
        wp <= wp + step;
        if (cnt == '0) begin
          irq <= 1'b1;
          if (rep) cnt <= rld;
          else     en  <= 1'b0;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end

      if (wr_en) begin
        case (wr_idx)
          IX_CTRL: begin
            if (wr_data[CB_EN] && !en) fresh <= 1'b1;
            en  <= wr_data[CB_EN];
            rep <= wr_data[CB_REP];
            sz  <= wr_data[CB_SZ];
            sf  <= wr_data[CB_SF];
            df  <= wr_data[CB_DF] && !wr_data[CB_SF];
            sel <= trig_t'(wr_data[CB_SEL +: 2]);
          end
          IX_SRC: if (sf || !en) src <= wr_data;
          IX_DST: if (df || !en) dst <= wr_data;
          IX_RLD: rld <= wr_data[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign pend_out = pend;
  assign en_out   = en;
  assign rep_out  = rep;
  assign sz_out   = sz;
endmodule

// File: rtl/dma2_arb.sv
module dma2_arb #(
  parameter int NCH   = 2,
  parameter int SEL_W = 1
) (
  input  logic [NCH-1:0]   req,
  output logic [NCH-1:0]   gnt,
  output logic [SEL_W-1:0] gnt_idx,
  output logic             any
);
  assign gnt[0] = req[0];
  for (genvar i = 1; i < NCH; i++) begin : g_pri
    assign gnt[i] = req[i] && !(|req[i-1:0]);
  end

  always_comb begin
    gnt_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) gnt_idx = SEL_W'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/dma2_seq.sv
module dma2_seq
  import dma2_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int SEL_W  = 1,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    req,
  input  logic [ADDR_W-1:0] src_eff [NCH],
  input  logic [ADDR_W-1:0] dst_eff [NCH],
  input  logic [NCH-1:0]    sz,
  output logic [NCH-1:0]    start,
  output logic [NCH-1:0]    done,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_size16,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready
);
  seq_state_t       st;
  logic [SEL_W-1:0] cur, gidx;
  logic [NCH-1:0]   gnt;
  logic             any;

  dma2_arb #(.NCH(NCH), .SEL_W(SEL_W)) u_arb (
    .req(req), .gnt(gnt), .gnt_idx(gidx), .any(any)
  );

  assign start = (st == SEQ_IDLE) ? gnt : '0;
  for (genvar i = 0; i < NCH; i++) begin : g_done
    assign done[i] = (st == SEQ_WR) && bus_ready && (cur == SEL_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SEQ_IDLE; cur <= '0; bus_req <= 1'b0; bus_we <= 1'b0;
      bus_addr <= '0; bus_wdata <= '0; bus_size16 <= 1'b0;
    end else begin
      case (st)
        SEQ_IDLE: if (any) begin
          cur        <= gidx;
          bus_req    <= 1'b1;
          bus_we     <= 1'b0;
          bus_addr   <= src_eff[gidx];
          bus_size16 <= sz[gidx];
          st         <= SEQ_RD;
        end
        SEQ_RD: if (bus_ready) begin
          bus_we    <= 1'b1;
          bus_addr  <= dst_eff[cur];
          bus_wdata <= bus_size16 ? bus_rdata : {{(DATA_W-8){1'b0}}, bus_rdata[7:0]};
          st        <= SEQ_WR;
        end
        SEQ_WR: if (bus_ready) begin
          bus_req <= 1'b0;
          bus_we  <= 1'b0;
          st      <= SEQ_IDLE;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma2_cycle_steal.sv
module dma2_cycle_steal
  import dma2_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  localparam int SEL_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int REG_AW = IDX_W + SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic [NCH-1:0]    trig_pin,
  input  logic [NCH-1:0]    periph_req,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_size16,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  output logic [NCH-1:0]    dma_irq
);
  logic [ADDR_W-1:0] rd_val  [NCH];
  logic [ADDR_W-1:0] src_eff [NCH];
  logic [ADDR_W-1:0] dst_eff [NCH];
  logic [NCH-1:0]    pend, ch_en, ch_rep, ch_sz, start, done, ready_req;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma2_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst(rst),
      .wr_en(reg_wr && (reg_addr[REG_AW-1:IDX_W] == SEL_W'(g))),
      .wr_idx(reg_addr[IDX_W-1:0]), .wr_data(reg_wdata),
      .rd_idx(reg_addr[IDX_W-1:0]), .rd_val(rd_val[g]),
      .pin(trig_pin[g]), .periph(periph_req[g]),
      .start(start[g]), .done(done[g]),
      .pend_out(pend[g]), .en_out(ch_en[g]), .rep_out(ch_rep[g]), .sz_out(ch_sz[g]),
      .src_eff(src_eff[g]), .dst_eff(dst_eff[g]), .irq(dma_irq[g])
    );
    assign ready_req[g] = pend[g] && ch_en[g];
  end

  dma2_seq #(.NCH(NCH), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .req(ready_req), .src_eff(src_eff), .dst_eff(dst_eff),
    .sz(ch_sz), .start(start), .done(done),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_size16(bus_size16), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_val[reg_addr[REG_AW-1:IDX_W]];
  end
endmodule

// File: rtl/dma2_cycle_steal_chk.sv
module dma2_cycle_steal_chk #(
  parameter int NCH    = 2,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NCH-1:0]    dma_irq,
  input logic [NCH-1:0]    ch_en,
  input logic [NCH-1:0]    ch_rep
);
  // R2
  we_in_req_chk: assert property (@(posedge clk) disable iff (rst) bus_we |-> bus_req);
  // R2
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ready) |=> ($stable(bus_addr) && $stable(bus_we) && bus_req));
  // R2
  read_before_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_we) |-> $past(bus_req && !bus_we && bus_ready));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R4
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
      dma_irq[i] |=> !dma_irq[i]);
    // R5
    single_stops_chk: assert property (@(posedge clk) disable iff (rst)
      (dma_irq[i] && !ch_rep[i] && !$past(reg_wr)) |-> !ch_en[i]);
    // R6
    repeat_stays_chk: assert property (@(posedge clk) disable iff (rst)
      (dma_irq[i] && ch_rep[i] && !$past(reg_wr)) |-> ch_en[i]);
  end
endmodule

bind dma2_cycle_steal dma2_cycle_steal_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .bus_req(bus_req), .bus_we(bus_we),
  .bus_ready(bus_ready), .bus_addr(bus_addr), .dma_irq(dma_irq),
  .ch_en(ch_en), .ch_rep(ch_rep)
);

// File: tb/dma2_cycle_steal_tb.sv
module dma2_cycle_steal_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [19:0] reg_wdata = '0;
  logic [19:0] reg_rdata;
  logic [1:0]  trig_pin = '0;
  logic [1:0]  periph_req = '0;
  logic        bus_req, bus_we, bus_size16, bus_ready;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [1:0]  dma_irq;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit rdy_slow = 0, finished = 0;
  int irq_cnt [2];
  logic [19:0] la [$];
  logic [15:0] ld [$];
  logic [19:0] rv;

  always #10 clk = ~clk;

  function automatic logic [15:0] data_of(input logic [19:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction
  assign bus_rdata = data_of(bus_addr);

  dma2_cycle_steal u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .trig_pin(trig_pin), .periph_req(periph_req),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_size16(bus_size16), .bus_rdata(bus_rdata), .bus_ready(bus_ready), .dma_irq(dma_irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #5 bus_ready = rdy_slow ? ((cyc % 3) == 2) : 1'b1;
  end

  // ---------------- reference model ----------------
  int          ms, mcur;
  logic        mreq, mwe, msz;
  logic [19:0] maddr, mrd;
  logic [15:0] mwd;
  logic [1:0]  mirq;
  bit          men[2], mrep[2], mszc[2], msf[2], mdf[2], mfresh[2], mpend[2], mpin[2];
  logic [1:0]  msel[2];
  logic [19:0] msrc[2], mdst[2], mwp[2];
  logic [15:0] mrld[2], mcnt[2];

  always @(posedge clk) begin : ref_model
    logic [19:0] se[2], de[2];
    bit st[2], dn[2], eo[2], sfo[2], dfo[2], req, fall, rise, kick;
    int rc;
    if (rst) begin
      ms = 0; mcur = 0; mreq = 0; mwe = 0; msz = 0; maddr = 0; mwd = 0; mirq = 0; mrd = 0;
      for (int c = 0; c < 2; c++) begin
        men[c] = 0; mrep[c] = 0; mszc[c] = 0; msf[c] = 0; mdf[c] = 0; mfresh[c] = 0;
        mpend[c] = 0; mpin[c] = 0; msel[c] = 0; msrc[c] = 0; mdst[c] = 0; mwp[c] = 0;
        mrld[c] = 0; mcnt[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        se[c] = (msf[c] && !mfresh[c]) ? mwp[c] : msrc[c];
        de[c] = (mdf[c] && !mfresh[c]) ? mwp[c] : mdst[c];
        eo[c] = men[c]; sfo[c] = msf[c]; dfo[c] = mdf[c]; st[c] = 0; dn[c] = 0;
      end
      rc = reg_addr[3];
      case (reg_addr[2:0])
        3'd0: mrd = {13'd0, msel[rc], mdf[rc], msf[rc], mszc[rc], mrep[rc], men[rc]};
        3'd1: mrd = (men[rc] && msf[rc] && !mfresh[rc]) ? mwp[rc] : msrc[rc];
        3'd2: mrd = (men[rc] && mdf[rc] && !mfresh[rc]) ? mwp[rc] : mdst[rc];
        3'd3: mrd = {4'd0, mrld[rc]};
        3'd4: mrd = {4'd0, mcnt[rc]};
        default: mrd = 0;
      endcase
      mirq = 0;
      case (ms)
        0: begin
          if (mpend[0] && men[0]) begin st[0] = 1; mcur = 0; end
          else if (mpend[1] && men[1]) begin st[1] = 1; mcur = 1; end
          if (st[0] || st[1]) begin
            mreq = 1; mwe = 0; maddr = se[mcur]; msz = mszc[mcur]; ms = 1;
          end
        end
        1: if (bus_ready) begin
          mwd = msz ? data_of(maddr) : {8'h00, data_of(maddr)[7:0]};
          mwe = 1; maddr = de[mcur]; ms = 2;
        end
        default: if (bus_ready) begin
          dn[mcur] = 1; mreq = 0; mwe = 0; ms = 0;
        end
      endcase
      for (int c = 0; c < 2; c++) begin
        fall = mpin[c] && !trig_pin[c];
        rise = !mpin[c] && trig_pin[c];
        kick = reg_wr && (reg_addr[3] == c[0]) && (reg_addr[2:0] == 3'd5);
        req = eo[c] && (kick || (msel[c] == 2'd1 && fall) || (msel[c] == 2'd2 && (fall || rise)) ||
                        (msel[c] == 2'd3 && periph_req[c]));
        if (!eo[c]) mpend[c] = 0;
        else if (req) mpend[c] = 1;
        else if (dn[c]) mpend[c] = 0;
        mpin[c] = trig_pin[c];
        if (st[c] && mfresh[c]) begin
          mcnt[c] = mrld[c]; mwp[c] = msf[c] ? msrc[c] : mdst[c]; mfresh[c] = 0;
        end
        if (dn[c]) begin
          mwp[c] = mwp[c] + (mszc[c] ? 20'd2 : 20'd1);
          if (mcnt[c] == 0) begin
            mirq[c] = 1;
            if (mrep[c]) mcnt[c] = mrld[c]; else men[c] = 0;
          end else mcnt[c] = mcnt[c] - 16'd1;
        end
        if (reg_wr && reg_addr[3] == c[0]) begin
          case (reg_addr[2:0])
            3'd0: begin
              if (reg_wdata[0] && !eo[c]) mfresh[c] = 1;
              men[c] = reg_wdata[0]; mrep[c] = reg_wdata[1]; mszc[c] = reg_wdata[2];
              msf[c] = reg_wdata[3]; mdf[c] = reg_wdata[4] && !reg_wdata[3]; msel[c] = reg_wdata[6:5];
            end
            3'd1: if (sfo[c] || !eo[c]) msrc[c] = reg_wdata;
            3'd2: if (dfo[c] || !eo[c]) mdst[c] = reg_wdata;
            3'd3: mrld[c] = reg_wdata[15:0];
            default: ;
          endcase
        end
      end
    end
  end

  // ---------------- per-clock comparison and logging ----------------
  always @(negedge clk) begin
    if (!rst) begin
      chk(bus_req === mreq, "R2 bus_req", 32'(bus_req), 32'(mreq));
      chk(bus_we === mwe, "R2 bus_we", 32'(bus_we), 32'(mwe));
      if (mreq) begin
        chk(bus_addr === maddr, "R3 bus_addr", 32'(bus_addr), 32'(maddr));
        chk(bus_size16 === msz, "R2 bus_size16", 32'(bus_size16), 32'(msz));
      end
      if (mwe) chk(bus_wdata === mwd, "R2 bus_wdata", 32'(bus_wdata), 32'(mwd));
      chk(dma_irq === mirq, "R4 dma_irq", 32'(dma_irq), 32'(mirq));
      chk(reg_rdata === mrd, "R8 reg_rdata", 32'(reg_rdata), 32'(mrd));
      if (bus_req && bus_we && bus_ready) begin
        la.push_back(bus_addr);
        ld.push_back(bus_wdata);
      end
      for (int c = 0; c < 2; c++) if (dma_irq[c]) irq_cnt[c]++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int ch, input int idx, input logic [19:0] d);
    @(posedge clk); #5;
    reg_wr = 1'b1; reg_addr = {ch[0], idx[2:0]}; reg_wdata = d;
    @(posedge clk); #5;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input int idx, output logic [19:0] v);
    @(posedge clk); #5;
    reg_addr = {ch[0], idx[2:0]};
    @(posedge clk);
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    irq_cnt[0] = 0; irq_cnt[1] = 0;
    repeat (3) @(posedge clk);
    #5 rst = 1'b0;

    // Reset state
    rd(0, 0, rv);
    chk(rv == 20'h0, "R8 ctrl after reset", 32'(rv), 0);
    chk(bus_req == 1'b0, "R2 bus idle after reset", 32'(bus_req), 0);

    // Channel 0: source forward, 8-bit, single, reload 2
    wr(0, 1, 20'h01000); wr(0, 2, 20'h00F00); wr(0, 3, 20'd2);
    wr(0, 0, 20'd9);
    la.delete(); ld.delete();
    wr(0, 5, 0); idle(8);
    rd(0, 1, rv);
    chk(rv == 20'h01001, "R8 forward read returns working pointer", 32'(rv), 32'h01001);
    wr(0, 5, 0); idle(8);
    wr(0, 5, 0); idle(8);
    chk(la.size() == 3, "R4 reload 2 gives 3 transfers", 32'(la.size()), 3);
    if (la.size() == 3) begin
      chk(la[0] == 20'h00F00 && la[2] == 20'h00F00, "R2 fixed destination", 32'(la[2]), 32'h00F00);
      chk(ld[0] == {8'h00, data_of(20'h01000)[7:0]}, "R3 first unit from loaded source", 32'(ld[0]),
          32'({8'h00, data_of(20'h01000)[7:0]}));
      chk(ld[2] == {8'h00, data_of(20'h01002)[7:0]}, "R3 source steps by 1", 32'(ld[2]),
          32'({8'h00, data_of(20'h01002)[7:0]}));
    end
    chk(irq_cnt[0] == 1, "R4 one underflow pulse", 32'(irq_cnt[0]), 1);
    rd(0, 0, rv);
    chk(rv == 20'd8, "R5 single mode cleared enable", 32'(rv), 8);
    rd(0, 1, rv);
    chk(rv == 20'h01000, "R8 disabled read returns stored source", 32'(rv), 32'h01000);
    wr(0, 5, 0); idle(8);
    chk(la.size() == 3, "R10 trigger ignored while disabled", 32'(la.size()), 3);

    // Channel 1: destination forward, 16-bit, repeat, falling pin, reload 1
    wr(1, 1, 20'h20000); wr(1, 2, 20'h00400); wr(1, 3, 20'd1);
    wr(1, 0, 20'd55);
    la.delete(); ld.delete();
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #5 trig_pin[1] = 1'b1; idle(6);
      trig_pin[1] = 1'b0; idle(8);
    end
    chk(la.size() == 3, "R10 falling edges only", 32'(la.size()), 3);
    if (la.size() == 3) begin
      chk(la[1] == 20'h00402, "R3 destination steps by 2", 32'(la[1]), 32'h00402);
      chk(la[2] == 20'h00404, "R6 pointer continues after reload", 32'(la[2]), 32'h00404);
      chk(ld[2] == data_of(20'h20000), "R2 16-bit data", 32'(ld[2]), 32'(data_of(20'h20000)));
    end
    chk(irq_cnt[1] == 1, "R4 underflow after second unit", 32'(irq_cnt[1]), 1);
    rd(1, 0, rv);
    chk(rv == 20'd55, "R6 repeat stays enabled", 32'(rv), 55);
    rd(1, 4, rv);
    chk(rv == 20'd0, "R4 counter after reload and one unit", 32'(rv), 0);
    rd(1, 2, rv);
    chk(rv == 20'h00406, "R8 working destination", 32'(rv), 32'h00406);
    wr(1, 1, 20'h12345);
    rd(1, 1, rv);
    chk(rv == 20'h20000, "R7 fixed source protected", 32'(rv), 32'h20000);
    wr(1, 2, 20'h00800);
    rd(1, 2, rv);
    chk(rv == 20'h00406, "R8 still working pointer", 32'(rv), 32'h00406);
    wr(1, 0, 20'd54);
    rd(1, 2, rv);
    chk(rv == 20'h00800, "R7 forward write accepted", 32'(rv), 32'h00800);

    // Both forward bits
    wr(0, 0, 20'd24);
    rd(0, 0, rv);
    chk(rv == 20'd8, "R9 destination forced fixed", 32'(rv), 8);

    // Both edges, fixed-fixed
    wr(0, 1, 20'h00010); wr(0, 2, 20'h00020); wr(0, 3, 20'd5);
    wr(0, 0, 20'd65);
    la.delete(); ld.delete();
    @(posedge clk); #5 trig_pin[0] = 1'b1; idle(8);
    trig_pin[0] = 1'b0; idle(8);
    chk(la.size() == 2, "R10 both edges", 32'(la.size()), 2);
    if (la.size() == 2)
      chk(la[1] == 20'h00020, "R2 fixed-fixed destination", 32'(la[1]), 32'h00020);

    // Merged requests
    la.delete();
    wr(0, 5, 0); wr(0, 5, 0); idle(10);
    chk(la.size() == 1, "R10 merged requests", 32'(la.size()), 1);

    // Priority with slow memory
    wr(0, 0, 20'd0);
    rdy_slow = 1'b1;
    wr(0, 1, 20'h00100); wr(0, 2, 20'h00200); wr(0, 3, 20'd3);
    wr(1, 1, 20'h00300); wr(1, 2, 20'h00400); wr(1, 3, 20'd3);
    wr(0, 0, 20'd97); wr(1, 0, 20'd97);
    la.delete();
    @(posedge clk); #5 periph_req = 2'b11;
    @(posedge clk); #5 periph_req = 2'b00;
    idle(30);
    chk(la.size() == 2, "R1 both channels served", 32'(la.size()), 2);
    if (la.size() == 2) begin
      chk(la[0] == 20'h00200, "R1 channel 0 first", 32'(la[0]), 32'h00200);
      chk(la[1] == 20'h00400, "R1 channel 1 second", 32'(la[1]), 32'h00400);
    end
    rdy_slow = 1'b0;
    idle(4);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule